// File: doc/BRIEF.md
# Alarm and Interrupt Flag Controller

This block merges three event sources into a single configurable interrupt pin. The sources are a masked BCD alarm compare against the time of day, a watchdog expiry input and a power-fail input. Each source sets a sticky flag. All flags are cleared together by one complete read of the flags register. The block holds the interrupt control register, four alarm registers and the flags register. All of them sit behind a small synchronous register bus.

The alarm compares the seconds, minutes, hours and date of the time of day with the stored values once per one-second tick. Bit 7 of each alarm register decides whether that field takes part in the compare. The pin stage can drive the pin push-pull and active high, or open-drain and active low. It can signal in level mode, where it holds until the flags are read, or in pulse mode, where it drops after a fixed number of slow reference ticks. The timekeeping counters sit outside the block and feed it BCD values and the second tick.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control register reads 8'h24, meaning power-fail enable, open-drain active low and pulse mode. All three flags are clear, and the pin is not driven (irq_oe=0, irq_out=0). The alarm registers reset to 8'h80.
- R2: The alarm flag is set only in a cycle with sec_tick high. It is set when every alarm field whose bit 7 is 0 has bits 6:0 equal to bits 6:0 of the matching time-of-day input. A field whose bit 7 is 1 is left out of the compare.
- R3: With every bit 7 set, the alarm fires on every tick. With seconds included, it fires only when the seconds agree. With seconds and minutes included, both must agree. Fields left out never block a match.
- R4: Register address 5 reads flags as bit 7 = watchdog, bit 6 = alarm and bit 5 = power-fail, with bits 4:0 reading 0. A one-cycle wdt_expire or pwr_fail pulse sets its flag.
- R5: All flags clear together when a read of address 5 completes. A read is complete when bus_sel falls after at least one cycle with bus_sel=1 and bus_wr=0 at that address. If bus_wr rises during the access, the access ends elsewhere, or the access reads another address, the flags are not cleared.
- R6: The control register is at address 0. Bit 7 enables the watchdog, bit 6 the alarm and bit 5 the power-fail source. Bit 4 is alarm-in-backup, bit 3 is active-high push-pull and bit 2 is pulse mode. Bits 1:0 read 0. The alarm registers are at addresses 1 to 4, in the order seconds, minutes, hours, date.
- R7: A source asserts the pin only while both its flag and its enable bit are 1. Any one such source is enough.
- R8: With bit 3 = 1, irq_out carries the active state and irq_oe is 1 only while on_backup=0. With bit 3 = 0, irq_out stays 0 and irq_oe carries the active state.
- R9: In level mode the pin stays active until the flags are cleared. In pulse mode it becomes active one cycle after the source rises and stays active for PULSE_TICKS cycles with slow_tick high. The flag remains set after the pulse ends.
- R10: A completed flags read ends a pulse in progress at once.
- R11: While on_backup=1, the alarm source asserts the pin only if alarm-in-backup is 1, and the power-fail source never asserts it.
- R12: If a source event arrives in the same cycle as a flag clear, that source's flag stays set and the other flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| slow_tick | input | 1 | Slow reference tick that times the pulse |
| tod_sec | input | 8 | BCD seconds of the time of day |
| tod_min | input | 8 | BCD minutes |
| tod_hour | input | 8 | BCD hours (24 h) |
| tod_date | input | 8 | BCD day of month |
| wdt_expire | input | 1 | Watchdog expiry event pulse |
| pwr_fail | input | 1 | Power-fail event pulse |
| on_backup | input | 1 | High while main power is below the switch level |
| bus_sel | input | 1 | Register access active |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq_out | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin output enable |
| flags_o | output | 3 | Flags {watchdog, alarm, power-fail} |

## Verification
The bench targets the flag clear. It runs an access that starts as a flags read and turns into a write, and a complete read of another register. A design that cleared on the read strobe alone would lose the watchdog flag in those cases. It also makes a watchdog event arrive exactly on the clearing edge. A design that gave the clear priority would drop that event. In pulse mode it counts the slow ticks to one short of the limit and then to the limit, so an off-by-one counter shows up. It also cuts a pulse short with a read, which catches a timer that ignores the clear. In backup mode it checks that a push-pull pin stays undriven and that alarm and power-fail obey the backup gating.

// File: rtl/alarm_irq_pkg.sv
// Shared register map, reset values and control-field view for the
// alarm and interrupt flag controller.
package alarm_irq_pkg;
    localparam int REG_AW       = 3;
    localparam int ALARM_FIELDS = 4;
    localparam int ALARM_BASE   = 1;

    typedef enum logic [REG_AW-1:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_FLAGS = 3'd5
    } reg_addr_e;

    localparam logic [7:0] CTRL_RESET  = 8'h24;
    localparam logic [7:0] ALARM_RESET = 8'h80;

    // Stored control bits 7:2, most significant first.
    typedef struct packed {
        logic wd_en;
        logic al_en;
        logic pf_en;
        logic al_bkp_en;
        logic act_high;
        logic pulse_mode;
    } irq_ctrl_t;
endpackage

// File: rtl/alarm_match.sv
// Masked compare of the alarm fields against the time of day.
// Assumes bit W-1 of each alarm field is the "leave out" bit and that the
// remaining bits are compared as raw BCD.
module alarm_match #(
    parameter int FIELDS = 4,
    parameter int W      = 8
) (
    input  logic [FIELDS-1:0][W-1:0] alarm_regs,
    input  logic [FIELDS-1:0][W-1:0] tod,
    output logic                     hit
);
    logic [FIELDS-1:0] field_ok;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        // A field passes when it is left out or its value agrees.
        assign field_ok[i] = alarm_regs[i][W-1] |
                             (alarm_regs[i][W-2:0] == tod[i][W-2:0]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/irq_pin_drive.sv
// Turns the combined source request into the pin value and enable.
// Handles level or pulse shaping and push-pull or open-drain drive.
// Assumes slow_tick is a one-cycle strobe and clear is a one-cycle flag clear.
module irq_pin_drive #(
    parameter int PULSE_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clear,
    input  logic slow_tick,
    input  logic pulse_mode,
    input  logic act_high,
    input  logic on_backup,
    output logic pin_out,
    output logic pin_oe
);
    localparam int CW = $clog2(PULSE_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_TICKS);

    logic          src_q;
    logic [CW-1:0] cnt_q;
    logic          active;

    // Remember the request so that its rising edge can start a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src;
    end

    // Pulse timer: load on a new request, cut by a clear, count slow ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (src && !src_q)           cnt_q <= LOAD;
        else if (clear)                   cnt_q <= '0;
        else if (slow_tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    // Pick the active state and the drive style.
    always_comb begin
        active = pulse_mode ? (cnt_q != '0) : src;
        if (act_high) begin
            pin_out = active;
            pin_oe  = !on_backup;
        end else begin
            pin_out = 1'b0;
            pin_oe  = active;
        end
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Top of the alarm and interrupt flag controller. Holds the control,
// alarm and flags registers, sets flags from the three sources, clears
// them on a complete flags read and feeds the pin stage.
// Assumes the bus is synchronous to clk and that event inputs are one-cycle pulses.
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int PULSE_TICKS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              slow_tick,
    input  logic [7:0]        tod_sec,
    input  logic [7:0]        tod_min,
    input  logic [7:0]        tod_hour,
    input  logic [7:0]        tod_date,
    input  logic              wdt_expire,
    input  logic              pwr_fail,
    input  logic              on_backup,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_out,
    output logic              irq_oe,
    output logic [2:0]        flags_o
);
    localparam int CTRL_BITS = $bits(irq_ctrl_t);

    irq_ctrl_t                        ctrl_q;
    logic [7:0]                       ctrl_word;
    logic [ALARM_FIELDS-1:0][7:0]     alarm_q;
    logic [ALARM_FIELDS-1:0][7:0]     tod_vec;
    logic                             alarm_hit;
    logic                             wd_flag, al_flag, pf_flag;
    logic                             rd_flags_q, flag_clr;
    logic                             set_wd, set_al, set_pf, set_any;
    logic                             wr_en, src;

    assign ctrl_word = {ctrl_q, {(8-CTRL_BITS){1'b0}}};
    assign tod_vec   = {tod_date, tod_hour, tod_min, tod_sec};
    assign wr_en     = bus_sel && bus_wr;

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= irq_ctrl_t'(CTRL_RESET[7:8-CTRL_BITS]);
        else if (wr_en && bus_addr == ADDR_CTRL) ctrl_q <= irq_ctrl_t'(bus_wdata[7:8-CTRL_BITS]);
    end

    // Alarm register writes, one address per field.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ALARM_FIELDS; i++) begin
            if (!rst_n)
                alarm_q[i] <= ALARM_RESET;
            else if (wr_en && bus_addr == REG_AW'(ALARM_BASE + i))
                alarm_q[i] <= bus_wdata;
        end
    end

    alarm_match #(.FIELDS(ALARM_FIELDS), .W(8)) u_match (
        .alarm_regs (alarm_q),
        .tod        (tod_vec),
        .hit        (alarm_hit)
    );

    assign set_wd  = wdt_expire;
    assign set_al  = sec_tick && alarm_hit;
    assign set_pf  = pwr_fail;
    assign set_any = set_wd || set_al || set_pf;

    // Track a pending flags read; it completes when the select falls.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_flags_q <= 1'b0;
        else        rd_flags_q <= bus_sel && !bus_wr && bus_addr == ADDR_FLAGS;
    end
    assign flag_clr = rd_flags_q && !bus_sel;

    // Sticky flags: a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
            al_flag <= 1'b0;
            pf_flag <= 1'b0;
        end else begin
            wd_flag <= set_wd || (wd_flag && !flag_clr);
            al_flag <= set_al || (al_flag && !flag_clr);
            pf_flag <= set_pf || (pf_flag && !flag_clr);
        end
    end
    assign flags_o = {wd_flag, al_flag, pf_flag};

    // Combine the enabled sources with the backup gating.
    assign src = (wd_flag && ctrl_q.wd_en) ||
                 (al_flag && ctrl_q.al_en && (!on_backup || ctrl_q.al_bkp_en)) ||
                 (pf_flag && ctrl_q.pf_en && !on_backup);

    irq_pin_drive #(.PULSE_TICKS(PULSE_TICKS)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (src),
        .clear      (flag_clr),
        .slow_tick  (slow_tick),
        .pulse_mode (ctrl_q.pulse_mode),
        .act_high   (ctrl_q.act_high),
        .on_backup  (on_backup),
        .pin_out    (irq_out),
        .pin_oe     (irq_oe)
    );

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL)  bus_rdata = ctrl_word;
        if (bus_addr == ADDR_FLAGS) bus_rdata = {flags_o, 5'b0};
        for (int i = 0; i < ALARM_FIELDS; i++)
            if (bus_addr == REG_AW'(ALARM_BASE + i)) bus_rdata = alarm_q[i];
    end
endmodule

// File: rtl/alarm_irq_chk.sv
// Property checker for alarm_irq_ctrl, attached by bind below.
// Assumes the reset is synchronous and asserted from time zero.
module alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       on_backup,
    input logic [7:0] ctrl,
    input logic       flag_clr,
    input logic       set_any,
    input logic [2:0] flags,
    input logic       irq_out,
    input logic       irq_oe
);
    AST_CTRL_RESET: assert property (@(posedge clk)
        !rst_n |=> (ctrl == 8'h24)); // R1

    AST_ALARM_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(sec_tick)); // R2

    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !set_any) |=> (flags == 3'b000)); // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((flags & $past(flags)) == $past(flags))); // R5

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[3] |-> !irq_out); // R8

    AST_PP_BACKUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3] && on_backup) |-> !irq_oe); // R8
endmodule

bind alarm_irq_ctrl alarm_irq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .on_backup (on_backup),
    .ctrl      (ctrl_word),
    .flag_clr  (flag_clr),
    .set_any   (set_any),
    .flags     (flags_o),
    .irq_out   (irq_out),
    .irq_oe    (irq_oe)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
// Scoreboard bench for alarm_irq_ctrl: each check pushes its expected
// value into a queue and the monitor step pops and compares it.
module alarm_irq_ctrl_tb_top;
    localparam int PT = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 0, slow_tick = 0, wdt_expire = 0, pwr_fail = 0, on_backup = 0;
    logic [7:0] tod_sec = 0, tod_min = 0, tod_hour = 0, tod_date = 8'h01;
    logic       bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq_out, irq_oe;
    logic [2:0] flags_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { string req; logic [7:0] exp; } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    alarm_irq_ctrl #(.PULSE_TICKS(PT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .slow_tick(slow_tick),
        .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
        .wdt_expire(wdt_expire), .pwr_fail(pwr_fail), .on_backup(on_backup),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .irq_oe(irq_oe), .flags_o(flags_o)
    );

    task automatic push_exp(string req, logic [7:0] e);
        item_t it;
        it.req = req;
        it.exp = e;
        exp_q.push_back(it);
    endtask

    task automatic monitor_pop(logic [7:0] act);
        item_t it;
        it = exp_q.pop_front();
        n_cmp++;
        if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] e);
        push_exp(req, e);
        monitor_pop(act);
    endtask

    task automatic reg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_wdt();
        @(negedge clk); wdt_expire = 1;
        @(posedge clk); @(negedge clk); wdt_expire = 0;
    endtask

    task automatic pulse_pf();
        @(negedge clk); pwr_fail = 1;
        @(posedge clk); @(negedge clk); pwr_fail = 0;
    endtask

    task automatic tick_sec();
        @(negedge clk); sec_tick = 1;
        @(posedge clk); @(negedge clk); sec_tick = 0;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        check("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
        check("R1 irq_out", {7'b0, irq_out}, 8'h00);
        reg_read(3'd0, d); check("R1 ctrl reset", d, 8'h24);
        reg_read(3'd3, d); check("R1 alarm reset", d, 8'h80);
        reg_read(3'd5, d); check("R1 flags reset", d, 8'h00);

        // R6 control layout, low bits read zero
        reg_write(3'd0, 8'hFF); reg_read(3'd0, d); check("R6 ctrl readback", d, 8'hFC);
        reg_write(3'd0, 8'h24);

        // R3 all fields left out: every tick fires
        tod_sec = 8'h17; tick_sec();
        reg_read(3'd5, d); check("R3 every tick", d, 8'h40);
        reg_read(3'd5, d); check("R5 second read empty", d, 8'h00);

        // R2 seconds included
        reg_write(3'd1, 8'h30);
        tod_sec = 8'h29; tick_sec();
        reg_read(3'd5, d); check("R2 seconds differ", d, 8'h00);
        tod_sec = 8'h30;
        settle();
        check("R2 no tick no flag", {5'b0, flags_o}, 8'h00);
        tick_sec();
        reg_read(3'd5, d); check("R2 seconds agree", d, 8'h40);

        // R3 seconds plus minutes, hours left out though differing
        reg_write(3'd2, 8'h15); reg_write(3'd3, 8'h85);
        tod_min = 8'h14; tod_hour = 8'h07; tick_sec();
        reg_read(3'd5, d); check("R3 minutes differ", d, 8'h00);
        tod_min = 8'h15; tick_sec();
        reg_read(3'd5, d); check("R3 hourly match", d, 8'h40);

        // R4 flag positions
        pulse_wdt(); reg_read(3'd5, d); check("R4 watchdog bit7", d, 8'h80);
        pulse_pf();  reg_read(3'd5, d); check("R4 power-fail bit5", d, 8'h20);
        pulse_wdt(); pulse_pf(); reg_read(3'd5, d); check("R4 two flags", d, 8'hA0);

        // R5 aborted read turned write, and read of another register
        pulse_wdt();
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd5;
        @(posedge clk); @(negedge clk); bus_wr = 1; bus_wdata = 8'h00;
        @(posedge clk); @(negedge clk); bus_sel = 0; bus_wr = 0;
        settle();
        check("R5 aborted read keeps", {5'b0, flags_o}, 8'h04);
        reg_read(3'd0, d);
        check("R5 other read keeps", {5'b0, flags_o}, 8'h04);
        reg_read(3'd5, d); check("R5 full read value", d, 8'h80);
        check("R5 cleared after read", {5'b0, flags_o}, 8'h00);

        // R7 R8 R9 level, push-pull, watchdog enabled only
        reg_write(3'd0, 8'h88);
        check("R8 push-pull idle oe", {7'b0, irq_oe}, 8'h01);
        pulse_wdt();
        check("R7 enabled source drives", {7'b0, irq_out}, 8'h01);
        reg_read(3'd5, d);
        check("R9 level drops on read", {7'b0, irq_out}, 8'h00);
        pulse_pf();
        check("R7 disabled source quiet", {7'b0, irq_out}, 8'h00);
        reg_read(3'd5, d);

        // R8 open-drain level
        reg_write(3'd0, 8'h20);
        pulse_pf();
        check("R8 open-drain oe", {7'b0, irq_oe}, 8'h01);
        check("R8 open-drain out low", {7'b0, irq_out}, 8'h00);
        reg_read(3'd5, d);

        // R9 pulse length
        reg_write(3'd0, 8'h24);
        pulse_pf();
        settle();
        check("R9 pulse started", {7'b0, irq_oe}, 8'h01);
        @(negedge clk); slow_tick = 1;
        repeat (PT - 1) @(posedge clk);
        @(negedge clk);
        check("R9 pulse one tick short", {7'b0, irq_oe}, 8'h01);
        @(posedge clk); @(negedge clk); slow_tick = 0;
        check("R9 pulse ended", {7'b0, irq_oe}, 8'h00);
        reg_read(3'd5, d); check("R9 flag outlives pulse", d, 8'h20);

        // R10 read cuts a pulse
        pulse_pf(); settle();
        check("R10 pulse running", {7'b0, irq_oe}, 8'h01);
        reg_read(3'd5, d);
        check("R10 pulse cut", {7'b0, irq_oe}, 8'h00);

        // R11 alarm in backup
        reg_write(3'd1, 8'h80); reg_write(3'd2, 8'h80); reg_write(3'd3, 8'h80);
        reg_write(3'd0, 8'h40);
        @(negedge clk); on_backup = 1;
        tick_sec();
        check("R11 alarm blocked in backup", {7'b0, irq_oe}, 8'h00);
        reg_write(3'd0, 8'h50);
        check("R11 alarm allowed in backup", {7'b0, irq_oe}, 8'h01);
        reg_write(3'd0, 8'h58);
        check("R8 push-pull off in backup", {7'b0, irq_oe}, 8'h00);
        @(negedge clk); on_backup = 0; #1;
        check("R8 push-pull on main power", {6'b0, irq_oe, irq_out}, 8'h03);
        reg_read(3'd5, d); check("R11 alarm flag", d, 8'h40);

        // R11 power-fail in backup
        reg_write(3'd0, 8'h20);
        @(negedge clk); on_backup = 1;
        pulse_pf();
        check("R11 power-fail blocked in backup", {7'b0, irq_oe}, 8'h00);
        @(negedge clk); on_backup = 0; #1;
        check("R11 power-fail on main power", {7'b0, irq_oe}, 8'h01);
        reg_read(3'd5, d);

        // R12 event on the clearing edge wins
        pulse_pf();
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 3'd5;
        @(posedge clk); @(negedge clk); bus_sel = 0; wdt_expire = 1;
        @(posedge clk); @(negedge clk); wdt_expire = 0;
        check("R12 set beats clear", {5'b0, flags_o}, 8'h04);

        finish_run();
    end
endmodule